// File: doc/BRIEF.md
# Near Relative Branch and Loop Resolver

This block settles the outcome of a near, relative control transfer in a 32-bit core's execute stage. Each request gives the block the address of the next sequential instruction, a signed displacement, an operation code, the arithmetic flags, the count register, the code segment limit and an address-size select. One cycle later the block returns where fetch should continue, whether the transfer was taken, the count value to write back with its enable, and a general-protection fault flag.

The block covers three groups of operation. The first is an unconditional jump. The second is a set of sixteen flag-tested jumps. The third is a jump on a zero count plus three counted loop forms. Every taken transfer is checked against the code segment limit. A loop whose target fails that check commits nothing, so the count register keeps its value from before the instruction and the fault can be restarted cleanly. With the address-size select low, only the low half of the count takes part and the upper half is written back unchanged.

Top module: `nbr_resolver`

## Requirements
- R1: While reset is high and after it falls, `out_valid`, `taken_o`, `count_we_o` and `gp_fault_o` are 0, and `ip_o` and `count_o` are 0 until the first request.
- R2: A request presented with `in_valid` high produces its results with `out_valid` high exactly one clock later. A cycle without `in_valid` gives `out_valid`, `taken_o`, `count_we_o` and `gp_fault_o` all 0.
- R3: The target is `nip_i` plus the sign-extended `disp_i`, modulo 2^32. On a taken transfer, `ip_o` equals the target.
- R4: Opcodes 0x00 to 0x0F are flag tests. Flag bits are: bit0 CF, bit1 PF, bit2 ZF, bit3 SF, bit4 OF. Codes 0/1 test OF set/clear, 2/3 CF, 4/5 ZF, 8/9 SF and 10/11 PF. Code 6 tests CF or ZF and 7 is its inverse. Code 12 tests SF not equal to OF and 13 is its inverse. Code 14 tests ZF, or SF not equal to OF, and 15 is its inverse.
- R5: Opcode 0x10 is an unconditional jump and is always taken, subject to R10.
- R6: Opcode 0x11 is taken when the active count is zero. It never asserts `count_we_o`, and `count_o` equals `count_i`.
- R7: Opcode 0x12 decrements the active count and is taken when the decremented value is nonzero. `count_we_o` is 1 and `count_o` is the decremented value, whether the branch is taken or not.
- R8: Opcode 0x13 behaves like 0x12 but is taken only when ZF is 1. Opcode 0x14 is taken only when ZF is 0. Both write back the count as in R7.
- R9: With `asize32_i` at 0, the zero test and the decrement use `count_i[15:0]` only, and `count_o[31:16]` equals `count_i[31:16]`. With `asize32_i` at 1, all 32 bits are used.
- R10: When a transfer's condition holds and its target is strictly greater than `cs_limit_i`, `gp_fault_o` is 1, `taken_o` is 0 and `ip_o` equals `nip_i`. A target equal to the limit does not fault.
- R11: A loop form that faults under R10 drives `count_we_o` to 0 and `count_o` to `count_i`.
- R12: When the condition does not hold, `ip_o` equals `nip_i` and `gp_fault_o` is 0, even if the target would exceed the limit.
- R13: Opcodes 0x15 to 0x1F are never taken. They write no count and raise no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op_i | input | 5 | Operation code |
| nip_i | input | 32 | Next sequential instruction address |
| disp_i | input | 32 | Signed displacement |
| flags_i | input | 5 | Flags: OF, SF, ZF, PF, CF from bit 4 down to bit 0 |
| count_i | input | 32 | Count register value |
| cs_limit_i | input | 32 | Code segment limit |
| asize32_i | input | 1 | 1: 32-bit count, 0: 16-bit count |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| ip_o | output | 32 | Address to continue fetching from |
| taken_o | output | 1 | Transfer taken |
| count_o | output | 32 | Count value to write back |
| count_we_o | output | 1 | Count write enable |
| gp_fault_o | output | 1 | Limit fault |

## Verification
All sixteen flag tests are applied with all 32 flag combinations. This separates each code from its inverse and from its neighbours, and catches a wrong flag bit or a dropped inversion. The loop forms are driven with counts of one, two, zero and values whose low half wraps, in both address sizes. These patterns separate a decrement that tests the old value from one that tests the new value, and show whether the upper half is preserved. Targets placed exactly at the limit, one above it, and far beyond it behind a false condition separate a strict comparison from an inclusive one, and show whether a check is made only on taken transfers. A final fault case on a loop shows whether the count write is held back.

// File: rtl/nbr_pkg.sv
package nbr_pkg;

    // Flag bundle; bit order matches the flags_i port (bit4 OF .. bit0 CF)
    typedef struct packed {
        logic of_f;
        logic sf_f;
        logic zf_f;
        logic pf_f;
        logic cf_f;
    } flags_t;

    typedef enum logic [2:0] {
        K_COND   = 3'd0,
        K_JMP    = 3'd1,
        K_JCZ    = 3'd2,
        K_LOOP   = 3'd3,
        K_LOOPZ  = 3'd4,
        K_LOOPNZ = 3'd5,
        K_NONE   = 3'd6
    } kind_e;

    localparam logic [4:0] OPC_JMP    = 5'h10;
    localparam logic [4:0] OPC_JCZ    = 5'h11;
    localparam logic [4:0] OPC_LOOP   = 5'h12;
    localparam logic [4:0] OPC_LOOPZ  = 5'h13;
    localparam logic [4:0] OPC_LOOPNZ = 5'h14;

    function automatic kind_e classify(input logic [4:0] op);
        kind_e k;
        if (!op[4]) begin
            k = K_COND;
        end else begin
            case (op)
                OPC_JMP:    k = K_JMP;
                OPC_JCZ:    k = K_JCZ;
                OPC_LOOP:   k = K_LOOP;
                OPC_LOOPZ:  k = K_LOOPZ;
                OPC_LOOPNZ: k = K_LOOPNZ;
                default:    k = K_NONE;
            endcase
        end
        return k;
    endfunction

    function automatic logic is_loop(input kind_e k);
        return (k == K_LOOP) || (k == K_LOOPZ) || (k == K_LOOPNZ);
    endfunction

endpackage

// File: rtl/nbr_cond_eval.sv
module nbr_cond_eval
    import nbr_pkg::*;
(
    input  flags_t     flags,
    input  logic [3:0] cc,
    output logic       met
);
    logic base;

    // Pairs share a test; bit 0 of the code inverts it
    always_comb begin
        case (cc[3:1])
            3'd0: base = flags.of_f;
            3'd1: base = flags.cf_f;
            3'd2: base = flags.zf_f;
            3'd3: base = flags.cf_f | flags.zf_f;
            3'd4: base = flags.sf_f;
            3'd5: base = flags.pf_f;
            3'd6: base = flags.sf_f ^ flags.of_f;
            default: base = flags.zf_f | (flags.sf_f ^ flags.of_f);
        endcase
        met = base ^ cc[0];
    end
endmodule

// File: rtl/nbr_count_unit.sv
module nbr_count_unit #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] count_in,
    input  logic             wide,
    output logic             is_zero,
    output logic             dec_nonzero,
    output logic [CNT_W-1:0] dec_val
);
    localparam int HALF = CNT_W / 2;

    logic [CNT_W-1:0] dec_full;
    logic [HALF-1:0]  dec_low;

    assign dec_full = count_in - CNT_W'(1);
    assign dec_low  = count_in[HALF-1:0] - HALF'(1);

    always_comb begin
        if (wide) begin
            is_zero     = (count_in == '0);
            dec_val     = dec_full;
            dec_nonzero = (dec_full != '0);
        end else begin
            is_zero     = (count_in[HALF-1:0] == '0);
            dec_val     = {count_in[CNT_W-1:HALF], dec_low};
            dec_nonzero = (dec_low != '0);
        end
    end
endmodule

// File: rtl/nbr_target_check.sv
module nbr_target_check #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 32
) (
    input  logic [ADDR_W-1:0] nip,
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] limit,
    output logic [ADDR_W-1:0] target,
    output logic              over_limit
);
    logic [ADDR_W-1:0] disp_ext;

    generate
        if (DISP_W < ADDR_W) begin : g_sext
            assign disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
        end else begin : g_full
            assign disp_ext = disp[ADDR_W-1:0];
        end
    endgenerate

    assign target     = nip + disp_ext;
    assign over_limit = (target > limit);
endmodule

// File: rtl/nbr_resolver.sv
module nbr_resolver
    import nbr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [4:0]        op_i,
    input  logic [ADDR_W-1:0] nip_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [4:0]        flags_i,
    input  logic [ADDR_W-1:0] count_i,
    input  logic [ADDR_W-1:0] cs_limit_i,
    input  logic              asize32_i,
    output logic              out_valid,
    output logic [ADDR_W-1:0] ip_o,
    output logic              taken_o,
    output logic [ADDR_W-1:0] count_o,
    output logic              count_we_o,
    output logic              gp_fault_o
);
    localparam int HALF = ADDR_W / 2;

    flags_t            fl;
    kind_e             kind;
    logic              cc_met, cnt_zero, dec_nz, over, want, loop_op;
    logic [ADDR_W-1:0] target, dec_val;

    assign fl   = flags_t'(flags_i);
    assign kind = classify(op_i);

    nbr_cond_eval u_cond (
        .flags (fl),
        .cc    (op_i[3:0]),
        .met   (cc_met)
    );

    nbr_count_unit #(.CNT_W(ADDR_W)) u_cnt (
        .count_in    (count_i),
        .wide        (asize32_i),
        .is_zero     (cnt_zero),
        .dec_nonzero (dec_nz),
        .dec_val     (dec_val)
    );

    nbr_target_check #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
        .nip        (nip_i),
        .disp       (disp_i),
        .limit      (cs_limit_i),
        .target     (target),
        .over_limit (over)
    );

    always_comb begin
        case (kind)
            K_COND:   want = cc_met;
            K_JMP:    want = 1'b1;
            K_JCZ:    want = cnt_zero;
            K_LOOP:   want = dec_nz;
            K_LOOPZ:  want = dec_nz & fl.zf_f;
            K_LOOPNZ: want = dec_nz & ~fl.zf_f;
            default:  want = 1'b0;
        endcase
        loop_op = is_loop(kind);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            ip_o       <= '0;
            taken_o    <= 1'b0;
            count_o    <= '0;
            count_we_o <= 1'b0;
            gp_fault_o <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                taken_o    <= want & ~over;
                gp_fault_o <= want & over;
                ip_o       <= (want & ~over) ? target : nip_i;
                count_we_o <= loop_op & ~(want & over);
                count_o    <= (loop_op & ~(want & over)) ? dec_val : count_i;
            end else begin
                taken_o    <= 1'b0;
                gp_fault_o <= 1'b0;
                count_we_o <= 1'b0;
            end
        end
    end

    // R2: result strobe follows the request strobe by one cycle
    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !taken_o && !count_we_o && !gp_fault_o));
    // R10: a fault never coincides with a taken transfer
    p_fault_not_taken_r10: assert property (@(posedge clk) disable iff (rst)
        gp_fault_o |-> !taken_o);
    // R10: a taken target always lies within the limit
    p_taken_in_limit_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && taken_o) |-> (ip_o <= $past(cs_limit_i)));
    // R11: no count commit alongside a fault
    p_fault_no_write_r11: assert property (@(posedge clk) disable iff (rst)
        gp_fault_o |-> !count_we_o);
    // R12: untaken results leave the pointer at the next instruction
    p_untaken_ip_r12: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !taken_o) |-> (ip_o == $past(nip_i)));
    // R9: narrow count write-back keeps the upper half
    p_upper_kept_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(asize32_i)) |->
            (count_o[ADDR_W-1:HALF] == $past(count_i[ADDR_W-1:HALF])));
    // R13: unused opcodes have no effect
    p_unused_quiet_r13: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_i > OPC_LOOPNZ) |=> (!taken_o && !count_we_o && !gp_fault_o));
endmodule

// File: tb/nbr_resolver_test.sv
module nbr_resolver_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [4:0]  op_i;
    logic [31:0] nip_i, disp_i, count_i, cs_limit_i;
    logic [4:0]  flags_i;
    logic        asize32_i;
    logic        out_valid, taken_o, count_we_o, gp_fault_o;
    logic [31:0] ip_o, count_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    nbr_resolver uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_i(op_i),
        .nip_i(nip_i), .disp_i(disp_i), .flags_i(flags_i), .count_i(count_i),
        .cs_limit_i(cs_limit_i), .asize32_i(asize32_i), .out_valid(out_valid),
        .ip_o(ip_o), .taken_o(taken_o), .count_o(count_o),
        .count_we_o(count_we_o), .gp_fault_o(gp_fault_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Flag order: bit0 CF, bit1 PF, bit2 ZF, bit3 SF, bit4 OF
    function automatic bit ref_cond(input logic [3:0] cc, input logic [4:0] f);
        bit cf = f[0], pf = f[1], zf = f[2], sf = f[3], of_ = f[4];
        case (cc)
            4'h0: return of_;
            4'h1: return !of_;
            4'h2: return cf;
            4'h3: return !cf;
            4'h4: return zf;
            4'h5: return !zf;
            4'h6: return cf || zf;
            4'h7: return !(cf || zf);
            4'h8: return sf;
            4'h9: return !sf;
            4'hA: return pf;
            4'hB: return !pf;
            4'hC: return sf != of_;
            4'hD: return sf == of_;
            4'hE: return zf || (sf != of_);
            default: return !zf && (sf == of_);
        endcase
    endfunction

    task automatic apply(input string tag, input logic [4:0] op,
                         input logic [31:0] nip, input logic [31:0] disp,
                         input logic [4:0] fl, input logic [31:0] cnt,
                         input logic [31:0] lim, input logic a32);
        logic [31:0] tgt, dec, e_ip, e_cnt;
        bit act_zero, dec_nz, met, loopy, e_fault, e_taken, e_we;
        tgt = nip + disp;
        if (a32) begin
            act_zero = (cnt == 0);
            dec      = cnt - 1;
            dec_nz   = (dec != 0);
        end else begin
            act_zero = (cnt[15:0] == 0);
            dec      = {cnt[31:16], 16'(cnt[15:0] - 16'd1)};
            dec_nz   = (dec[15:0] != 0);
        end
        loopy = (op == 5'h12 || op == 5'h13 || op == 5'h14);
        if (op < 5'h10)       met = ref_cond(op[3:0], fl);
        else if (op == 5'h10) met = 1;
        else if (op == 5'h11) met = act_zero;
        else if (op == 5'h12) met = dec_nz;
        else if (op == 5'h13) met = dec_nz && fl[2];
        else if (op == 5'h14) met = dec_nz && !fl[2];
        else                  met = 0;
        e_fault = met && (tgt > lim);
        e_taken = met && !e_fault;
        e_ip    = e_taken ? tgt : nip;
        e_we    = loopy && !e_fault;
        e_cnt   = e_we ? dec : cnt;

        @(negedge clk);
        in_valid = 1; op_i = op; nip_i = nip; disp_i = disp; flags_i = fl;
        count_i = cnt; cs_limit_i = lim; asize32_i = a32;
        @(negedge clk);
        in_valid = 0;
        check(tag, "out_valid", 32'(out_valid), 32'd1);
        check(tag, "taken", 32'(taken_o), 32'(e_taken));
        check(tag, "fault", 32'(gp_fault_o), 32'(e_fault));
        check(tag, "ip", ip_o, e_ip);
        check(tag, "count_we", 32'(count_we_o), 32'(e_we));
        check(tag, "count", count_o, e_cnt);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "out_valid", 32'(out_valid), 0);
        check("R1", "taken", 32'(taken_o), 0);
        check("R1", "count_we", 32'(count_we_o), 0);
        check("R1", "fault", 32'(gp_fault_o), 0);
        check("R1", "ip", ip_o, 0);
        check("R1", "count", count_o, 0);
    endtask

    task automatic t_idle();
        apply("R2", 5'h10, 32'h100, 32'h10, 0, 32'h5, 32'hFFFF, 1);
        @(negedge clk);
        check("R2", "out_valid idle", 32'(out_valid), 0);
        check("R2", "taken idle", 32'(taken_o), 0);
        check("R2", "count_we idle", 32'(count_we_o), 0);
    endtask

    task automatic t_target();
        apply("R3", 5'h10, 32'h2000, 32'hFFFF_FF00, 0, 0, 32'hFFFF_FFFF, 1);
        apply("R3", 5'h10, 32'hFFFF_FFF0, 32'h20, 0, 0, 32'hFFFF_FFFF, 1);
    endtask

    task automatic t_conds();
        for (int cc = 0; cc < 16; cc++)
            for (int f = 0; f < 32; f++)
                apply("R4", 5'(cc), 32'h1000, 32'h40, 5'(f), 32'h7, 32'hFFFF, 1);
    endtask

    task automatic t_jmp();
        apply("R5", 5'h10, 32'h300, 32'hFFFF_FFFC, 5'h1F, 0, 32'h1000, 0);
    endtask

    task automatic t_jcz();
        apply("R6", 5'h11, 32'h400, 32'h8, 0, 32'h0, 32'hFFFF, 1);
        apply("R6", 5'h11, 32'h400, 32'h8, 0, 32'h1, 32'hFFFF, 1);
        apply("R6", 5'h11, 32'h400, 32'h8, 0, 32'h5_0000, 32'hFFFF, 0);
    endtask

    task automatic t_loop();
        apply("R7", 5'h12, 32'h500, 32'hFFFF_FFF0, 0, 32'h2, 32'hFFFF, 1);
        apply("R7", 5'h12, 32'h500, 32'hFFFF_FFF0, 0, 32'h1, 32'hFFFF, 1);
        apply("R7", 5'h12, 32'h500, 32'hFFFF_FFF0, 0, 32'h0, 32'hFFFF, 1);
    endtask

    task automatic t_loopz();
        apply("R8", 5'h13, 32'h600, 32'h20, 5'h04, 32'h3, 32'hFFFF, 1);
        apply("R8", 5'h13, 32'h600, 32'h20, 5'h00, 32'h3, 32'hFFFF, 1);
        apply("R8", 5'h14, 32'h600, 32'h20, 5'h00, 32'h3, 32'hFFFF, 1);
        apply("R8", 5'h14, 32'h600, 32'h20, 5'h04, 32'h3, 32'hFFFF, 1);
        apply("R8", 5'h13, 32'h600, 32'h20, 5'h04, 32'h1, 32'hFFFF, 1);
    endtask

    task automatic t_asize();
        apply("R9", 5'h12, 32'h700, 32'h10, 0, 32'hABCD_0000, 32'hFFFF, 0);
        apply("R9", 5'h12, 32'h700, 32'h10, 0, 32'hABCD_0001, 32'hFFFF, 0);
        apply("R9", 5'h12, 32'h700, 32'h10, 0, 32'hABCD_0001, 32'hFFFF, 1);
        apply("R9", 5'h11, 32'h700, 32'h10, 0, 32'h0001_0000, 32'hFFFF, 0);
        apply("R9", 5'h11, 32'h700, 32'h10, 0, 32'h0001_0000, 32'hFFFF, 1);
    endtask

    task automatic t_limit();
        apply("R10", 5'h10, 32'h800, 32'h100, 0, 0, 32'h900, 1);
        apply("R10", 5'h10, 32'h800, 32'h101, 0, 0, 32'h900, 1);
        apply("R10", 5'h04, 32'h800, 32'h8000, 5'h04, 0, 32'h900, 1);
    endtask

    task automatic t_loop_fault();
        apply("R11", 5'h12, 32'h800, 32'h8000, 0, 32'h9, 32'h900, 1);
        apply("R11", 5'h14, 32'h800, 32'h8000, 0, 32'h1234_0009, 32'h900, 0);
    endtask

    task automatic t_untaken();
        apply("R12", 5'h05, 32'h800, 32'h8000, 5'h04, 0, 32'h900, 1);
        apply("R12", 5'h12, 32'h800, 32'h8000, 0, 32'h1, 32'h900, 1);
    endtask

    task automatic t_unused();
        for (int op = 5'h15; op < 32; op++)
            apply("R13", 5'(op), 32'h900, 32'h4, 5'h1F, 32'h0, 32'h0, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst = 1; in_valid = 0; op_i = 0; nip_i = 0; disp_i = 0; flags_i = 0;
        count_i = 0; cs_limit_i = 0; asize32_i = 1;
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst = 0;
        t_reset();
        t_idle();
        t_target();
        t_conds();
        t_jmp();
        t_jcz();
        t_loop();
        t_loopz();
        t_asize();
        t_limit();
        t_loop_fault();
        t_untaken();
        t_unused();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule